// File: doc/BRIEF.md
# Chainable Event Counter Bank

The block holds a set of 32-bit event counters for one slice of a shared cache. Each counter has an 8-bit event code. The code selects one line of a wide vector of single-cycle event pulses, and the counter adds one on every cycle that line is high while counting is allowed. Software reaches the block through a plain register port with address, write data, write strobe, read strobe and registered read data. The block has one interrupt output.

Counters sit in even/odd pairs. An odd counter can be switched so that it advances on the carry out of its even partner instead of on its own event. The pair then behaves as one 64-bit counter that never tears within a cycle. Each counter sets a sticky overflow status bit. By default the bit is set when the counter wraps. In the alternative mode it is set whenever the counter's most significant bit changes in either direction, which lets software leave a 32-bit counter free-running and still catch every half-range step.

Counting is gated at three levels: the unit enable, the per-counter enable, and the event line itself. Enables are changed through separate set and clear registers, so no read-modify-write is needed.

Top module: `evctr_bank`

## Requirements
- R1: After reset every counter, event code, enable mask, interrupt-enable mask, gang mask, MSB-mode mask and overflow status bit is 0, the read data is 0 and `irq` is low.
- R2: Counter n adds exactly one in a cycle when the unit enable is 1, enable bit n is 1, its event code c is nonzero and `evt_in[c]` is high. An event code of 0 never counts.
- R3: Control register 0x500: bit 0 is the unit enable, and no counter changes by counting while it is 0. Writing 1 to bit 1 zeroes every counter on that write. Bit 1 always reads back 0.
- R4: Writing 1 to bit n of 0x508 sets enable n, and writing 1 to bit n of 0x50C clears it. Zero bits leave the enable unchanged. Both addresses read back the current enable mask.
- R5: Counter n's value is at 0x420+8n and its event code at 0x220+8n, bits 7:0. A software write to a counter value takes effect even when an increment happens in the same cycle.
- R6: Gang register 0x718: setting bit n+1, for odd n+1, makes counter n+1 advance on the carry out of counter n, in the same cycle, instead of on its own event. Even bits of the gang register are ignored and read 0.
- R7: When a counter is not in MSB mode, its status bit in 0x740 is set when it wraps from all ones to zero by counting.
- R8: MSB-mode register 0x96C: when bit n is 1, status bit n is set whenever an increment changes bit 31 of counter n in either direction.
- R9: Status register 0x740 is write-1-to-clear, and a new overflow in the same cycle as the clear leaves the bit set.
- R10: Interrupt enables are set at 0x510 and cleared at 0x514, write-1 only. `irq` is high exactly when some status bit and its interrupt enable are both 1.
- R11: Read data appears one cycle after the read strobe. Addresses outside the map read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| evt_in | input | 256 | Event pulse lines, indexed by event code |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions check the following on every cycle:
- a software write lands exactly and wins over counting;
- an idle counter holds its value, and an enabled hit moves it by exactly one;
- the unit reset zeroes the counters;
- set-enable writes take hold;
- status bits clear on write-1 and are never lost when set;
- a carry out of a ganged odd counter leaves both halves at zero.

Other behaviours show up only in the bench's scenarios:
- event selection against random event traffic and random codes;
- code 0 never counting;
- 64-bit chaining across the low-word wrap;
- wrap versus MSB-toggle overflow in both directions of bit 31;
- the set-over-clear race on the status register;
- the interrupt gating.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

  // Register offsets that software decodes.
  localparam int unsigned ADR_CTRL    = 32'h500;
  localparam int unsigned ADR_ENSET   = 32'h508;
  localparam int unsigned ADR_ENCLR   = 32'h50C;
  localparam int unsigned ADR_IESET   = 32'h510;
  localparam int unsigned ADR_IECLR   = 32'h514;
  localparam int unsigned ADR_GANG    = 32'h718;
  localparam int unsigned ADR_STATUS  = 32'h740;
  localparam int unsigned ADR_MSBMODE = 32'h96C;
  localparam int unsigned EVSEL_BASE  = 32'h220;
  localparam int unsigned VALUE_BASE  = 32'h420;
  localparam int unsigned SLOT_STRIDE = 8;

  function automatic int unsigned slot_addr(input int unsigned base, input int unsigned idx);
    return base + SLOT_STRIDE * idx;
  endfunction

endpackage

// File: rtl/evctr_cell.sv
module evctr_cell #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             evt_hit,
  input  logic             chain_sel,
  input  logic             chain_cin,
  input  logic             clr,
  input  logic             wr,
  input  logic [CTR_W-1:0] wdata,
  input  logic             msb_mode,
  output logic [CTR_W-1:0] value,
  output logic             carry_out,
  output logic             ovf_set
);

  logic             inc;
  logic             adv;
  logic             msb_flip;
  logic [CTR_W-1:0] value_d;

  assign inc = cnt_en & (chain_sel ? chain_cin : evt_hit);
  assign adv = inc & ~clr & ~wr;

  // An increment flips the top bit exactly when all lower bits are ones.
  assign msb_flip  = adv & (&value[CTR_W-2:0]);
  assign carry_out = adv & (&value);
  assign ovf_set   = msb_mode ? msb_flip : carry_out;

  always_comb begin
    value_d = value;
    if (clr)      value_d = '0;
    else if (wr)  value_d = wdata;
    else if (inc) value_d = value + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= value_d;
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> value == $past(wdata)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr && !clr) |=> $stable(value)); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && evt_hit && !chain_sel && !wr && !clr) |=> value == $past(value) + 1'b1); // R2

  AST_UNIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> value == '0); // R3

endmodule

// File: rtl/evctr_regs.sv
module evctr_regs
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 32,
  parameter int SEL_W   = 8,
  parameter int ADDR_W  = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [CTR_W-1:0]                wdata,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [NUM_CTR-1:0][CTR_W-1:0]   ctr_val,
  input  logic [NUM_CTR-1:0]              ovf_set,
  output logic [CTR_W-1:0]                rd_data,
  output logic                            unit_en,
  output logic                            unit_clr,
  output logic [NUM_CTR-1:0]              ctr_en,
  output logic [NUM_CTR-1:0]              gang_en,
  output logic [NUM_CTR-1:0]              msb_mode,
  output logic [NUM_CTR-1:0][SEL_W-1:0]   evt_code,
  output logic [NUM_CTR-1:0]              ctr_wr,
  output logic [CTR_W-1:0]                ctr_wdata,
  output logic                            irq
);

  logic [NUM_CTR-1:0] odd_bits;
  logic [NUM_CTR-1:0] wmask;
  logic [NUM_CTR-1:0] sel_wr;
  logic hit_ctrl, hit_enset, hit_enclr, hit_ieset, hit_ieclr;
  logic hit_gang, hit_status, hit_msb;

  logic                          unit_en_d;
  logic [NUM_CTR-1:0]            en_d, ie_q, ie_d, gang_d, msb_d, ovf_q, ovf_d;
  logic [NUM_CTR-1:0][SEL_W-1:0] code_d;
  logic [CTR_W-1:0]              rd_d;

  assign wmask     = wdata[NUM_CTR-1:0];
  assign ctr_wdata = wdata;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
    assign odd_bits[i] = (i % 2 == 1);
    assign sel_wr[i]   = wr_en && (addr == ADDR_W'(slot_addr(EVSEL_BASE, i)));
    assign ctr_wr[i]   = wr_en && (addr == ADDR_W'(slot_addr(VALUE_BASE, i)));
  end

  always_comb begin
    hit_ctrl   = addr == ADDR_W'(ADR_CTRL);
    hit_enset  = addr == ADDR_W'(ADR_ENSET);
    hit_enclr  = addr == ADDR_W'(ADR_ENCLR);
    hit_ieset  = addr == ADDR_W'(ADR_IESET);
    hit_ieclr  = addr == ADDR_W'(ADR_IECLR);
    hit_gang   = addr == ADDR_W'(ADR_GANG);
    hit_status = addr == ADDR_W'(ADR_STATUS);
    hit_msb    = addr == ADDR_W'(ADR_MSBMODE);
  end

  assign unit_clr = wr_en & hit_ctrl & wdata[1];

  // Next-state logic.
  always_comb begin
    unit_en_d = (wr_en && hit_ctrl) ? wdata[0] : unit_en;
    en_d      = ctr_en;
    if (wr_en && hit_enset) en_d = en_d | wmask;
    if (wr_en && hit_enclr) en_d = en_d & ~wmask;
    ie_d      = ie_q;
    if (wr_en && hit_ieset) ie_d = ie_d | wmask;
    if (wr_en && hit_ieclr) ie_d = ie_d & ~wmask;
    gang_d    = (wr_en && hit_gang) ? (wmask & odd_bits) : gang_en;
    msb_d     = (wr_en && hit_msb)  ? wmask : msb_mode;
    ovf_d     = (ovf_q & ~((wr_en && hit_status) ? wmask : '0)) | ovf_set;
    for (int i = 0; i < NUM_CTR; i++)
      code_d[i] = sel_wr[i] ? wdata[SEL_W-1:0] : evt_code[i];
  end

  // Read multiplexer.
  always_comb begin
    rd_d = '0;
    if (hit_ctrl)              rd_d[0] = unit_en;
    if (hit_enset | hit_enclr) rd_d[NUM_CTR-1:0] = ctr_en;
    if (hit_ieset | hit_ieclr) rd_d[NUM_CTR-1:0] = ie_q;
    if (hit_gang)              rd_d[NUM_CTR-1:0] = gang_en;
    if (hit_status)            rd_d[NUM_CTR-1:0] = ovf_q;
    if (hit_msb)               rd_d[NUM_CTR-1:0] = msb_mode;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (addr == ADDR_W'(slot_addr(EVSEL_BASE, i))) rd_d = {{(CTR_W-SEL_W){1'b0}}, evt_code[i]};
      if (addr == ADDR_W'(slot_addr(VALUE_BASE, i))) rd_d = ctr_val[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_en  <= 1'b0;
      ctr_en   <= '0;
      ie_q     <= '0;
      gang_en  <= '0;
      msb_mode <= '0;
      ovf_q    <= '0;
      evt_code <= '0;
      rd_data  <= '0;
    end else begin
      unit_en  <= unit_en_d;
      ctr_en   <= en_d;
      ie_q     <= ie_d;
      gang_en  <= gang_d;
      msb_mode <= msb_d;
      ovf_q    <= ovf_d;
      evt_code <= code_d;
      if (rd_en) rd_data <= rd_d;
    end
  end

  assign irq = |(ovf_q & ie_q);

  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_status) |=> (ovf_q & $past(wmask & ~ovf_set)) == '0); // R9

  AST_STATUS_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(ovf_set) & ~ovf_q) == '0); // R9

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_enset) |=> ($past(wmask) & ~ctr_en) == '0); // R4

endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
  import evctr_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 32,
  parameter int SEL_W   = 8,
  parameter int ADDR_W  = 12,
  localparam int EVT_W  = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTR_W-1:0]  reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [CTR_W-1:0]  reg_rdata,
  input  logic [EVT_W-1:0]  evt_in,
  output logic              irq
);

  logic                          unit_en, unit_clr;
  logic [NUM_CTR-1:0]            ctr_en, gang_en, msb_mode, ctr_wr;
  logic [NUM_CTR-1:0][SEL_W-1:0] evt_code;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_val;
  logic [CTR_W-1:0]              ctr_wdata;
  logic [NUM_CTR-1:0]            evt_hit, carry, cin, ovf_set;

  evctr_regs #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .SEL_W   (SEL_W),
    .ADDR_W  (ADDR_W)
  ) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .wr_en     (reg_wr),
    .rd_en     (reg_rd),
    .ctr_val   (ctr_val),
    .ovf_set   (ovf_set),
    .rd_data   (reg_rdata),
    .unit_en   (unit_en),
    .unit_clr  (unit_clr),
    .ctr_en    (ctr_en),
    .gang_en   (gang_en),
    .msb_mode  (msb_mode),
    .evt_code  (evt_code),
    .ctr_wr    (ctr_wr),
    .ctr_wdata (ctr_wdata),
    .irq       (irq)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign evt_hit[i] = (evt_code[i] != '0) && evt_in[evt_code[i]];

    if (i % 2 == 1) begin : g_odd
      assign cin[i] = carry[i-1];

      AST_PAIR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (carry[i] && gang_en[i]) |=> (ctr_val[i] == '0 && ctr_val[i-1] == '0)); // R6
    end else begin : g_even
      assign cin[i] = 1'b0;
    end

    evctr_cell #(.CTR_W(CTR_W)) i_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (unit_en & ctr_en[i]),
      .evt_hit   (evt_hit[i]),
      .chain_sel (gang_en[i]),
      .chain_cin (cin[i]),
      .clr       (unit_clr),
      .wr        (ctr_wr[i]),
      .wdata     (ctr_wdata),
      .msb_mode  (msb_mode[i]),
      .value     (ctr_val[i]),
      .carry_out (carry[i]),
      .ovf_set   (ovf_set[i])
    );
  end

endmodule

// File: tb/test_evctr_bank.sv
`timescale 1ns/1ps
module test_evctr_bank;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [11:0]  addr;
  logic [31:0]  wdata;
  logic         wr, rd;
  logic [31:0]  rdata;
  logic [255:0] evt;
  logic         irq;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  evctr_bank i_evctr_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (addr),
    .reg_wdata (wdata),
    .reg_wr    (wr),
    .reg_rd    (rd),
    .reg_rdata (rdata),
    .evt_in    (evt),
    .irq       (irq)
  );

  function automatic logic [255:0] line(input int c);
    return 256'(1) << c;
  endfunction

  function automatic bit counts(input logic [255:0] v, input logic [7:0] code);
    return (code != 8'h00) && v[code];
  endfunction

  function automatic logic [11:0] val_adr(input int n);
    return 12'(32'h420 + 8 * n);
  endfunction

  function automatic logic [11:0] sel_adr(input int n);
    return 12'(32'h220 + 8 * n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d,
                        input logic [255:0] ev = '0);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; evt = ev;
    @(negedge clk);
    wr = 1'b0; evt = '0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [255:0] ev, input int n);
    repeat (n) begin
      @(negedge clk);
      evt = ev;
    end
    @(negedge clk);
    evt = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #1ms;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0]  r;
    logic [7:0]   code [8];
    logic [31:0]  model [8];
    logic [255:0] v;
    int           seed;

    seed = 7331;
    void'($urandom(seed));
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_reg(12'h500, r); chk("R1 ctrl", r, 32'h0);
    rd_reg(12'h508, r); chk("R1 enables", r, 32'h0);
    rd_reg(12'h740, r); chk("R1 status", r, 32'h0);
    rd_reg(val_adr(0), r); chk("R1 counter", r, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R11: unmapped address
    wr_reg(12'h100, 32'hFFFF_FFFF);
    rd_reg(12'h100, r); chk("R11 unmapped", r, 32'h0);
    // R5: event code field is 8 bits wide
    wr_reg(sel_adr(5), 32'h1A5);
    rd_reg(sel_adr(5), r); chk("R5 code field", r, 32'hA5);

    // R4: set/clear enables
    wr_reg(12'h508, 32'h0F);
    rd_reg(12'h508, r); chk("R4 set", r, 32'h0F);
    wr_reg(12'h50C, 32'h00);
    rd_reg(12'h508, r); chk("R4 zero clear", r, 32'h0F);
    wr_reg(12'h50C, 32'h05);
    rd_reg(12'h50C, r); chk("R4 clear", r, 32'h0A);
    wr_reg(12'h508, 32'hFF);

    // R2: random event traffic against random codes
    for (int c = 0; c < 8; c++) begin
      code[c]  = (c == 7) ? 8'h00 : 8'($urandom_range(255, 0));
      model[c] = 0;
      wr_reg(sel_adr(c), {24'h0, code[c]});
    end
    wr_reg(12'h500, 32'h1);
    for (int k = 0; k < 200; k++) begin
      for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom;
      @(negedge clk);
      evt = v;
      for (int c = 0; c < 8; c++) if (counts(v, code[c])) model[c]++;
    end
    @(negedge clk);
    evt = '0;
    wr_reg(12'h500, 32'h0);
    for (int c = 0; c < 8; c++) begin
      rd_reg(val_adr(c), r);
      chk((c == 7) ? "R2 code zero" : "R2 random count", r, model[c]);
    end

    // R3: unit disabled, then unit reset
    pulse({256{1'b1}}, 5);
    rd_reg(val_adr(0), r); chk("R3 unit off holds", r, model[0]);
    for (int c = 0; c < 8; c++) wr_reg(sel_adr(c), 32'h0);
    wr_reg(12'h500, 32'h3);
    rd_reg(12'h500, r); chk("R3 reset bit reads 0", r, 32'h1);
    rd_reg(val_adr(0), r); chk("R3 reset clears", r, 32'h0);
    rd_reg(val_adr(5), r); chk("R3 reset clears", r, 32'h0);

    // R5: software write beats a same-cycle increment
    wr_reg(sel_adr(0), 32'h21);
    wr_reg(val_adr(0), 32'h1234, line(8'h21));
    rd_reg(val_adr(0), r); chk("R5 write wins", r, 32'h1234);
    pulse(line(8'h21), 2);
    rd_reg(val_adr(0), r); chk("R2 directed count", r, 32'h1236);

    // R6: chained pair
    wr_reg(12'h718, 32'h3);
    rd_reg(12'h718, r); chk("R6 even gang ignored", r, 32'h2);
    wr_reg(val_adr(0), 32'hFFFF_FFFE);
    wr_reg(val_adr(1), 32'h5);
    pulse(line(8'h21), 3);
    rd_reg(val_adr(0), r); chk("R6 low word", r, 32'h1);
    rd_reg(val_adr(1), r); chk("R6 high word", r, 32'h6);

    // R7: wrap sets status only for the wrapping counter
    rd_reg(12'h740, r); chk("R7 wrap status", r, 32'h1);
    chk("R10 irq masked", {31'h0, irq}, 32'h0);

    // R10: interrupt enable set/clear
    wr_reg(12'h510, 32'h1);
    chk("R10 irq raised", {31'h0, irq}, 32'h1);
    wr_reg(12'h514, 32'h1);
    chk("R10 irq cleared by mask", {31'h0, irq}, 32'h0);
    wr_reg(12'h510, 32'h1);

    // R9: write-1-to-clear, and set beats clear
    wr_reg(12'h740, 32'h1);
    rd_reg(12'h740, r); chk("R9 w1c", r, 32'h0);
    chk("R10 irq after clear", {31'h0, irq}, 32'h0);
    wr_reg(sel_adr(2), 32'h22);
    wr_reg(val_adr(2), 32'hFFFF_FFFF);
    wr_reg(12'h740, 32'h4, line(8'h22));
    rd_reg(12'h740, r); chk("R9 set wins", r, 32'h4);

    // R8: MSB mode on counter 3, counter 4 left in wrap mode
    wr_reg(12'h96C, 32'h8);
    wr_reg(sel_adr(3), 32'h23);
    wr_reg(sel_adr(4), 32'h24);
    wr_reg(val_adr(3), 32'h7FFF_FFFF);
    wr_reg(val_adr(4), 32'h7FFF_FFFF);
    wr_reg(12'h740, 32'hFF);
    pulse(line(8'h23) | line(8'h24), 1);
    rd_reg(12'h740, r); chk("R8 msb rise", r, 32'h8);
    wr_reg(12'h740, 32'hFF);
    wr_reg(val_adr(3), 32'hFFFF_FFFF);
    pulse(line(8'h23), 1);
    rd_reg(12'h740, r); chk("R8 msb fall", r, 32'h8);
    rd_reg(val_adr(4), r); chk("R2 counter 4", r, 32'h8000_0000);

    summary();
    $finish;
  end

endmodule